// File: doc/BRIEF.md
# I2C Master Stop-Condition Controller

This block owns the stop request of a byte-oriented I2C master. Software writes a control word that carries a stop-request bit, a start-request bit, a release bit, an enable bit, an acknowledge-enable bit and a wait-point select bit. The block decides whether a stop request is taken. Once a request is taken, the block drives the stop sequence onto the open-drain SCL and SDA lines. It also clears the request when the bus, the arbitration logic or software ends it.

The bit engine next to this block reports the following status: master or slave role, transmitter or receiver role, whether the bus is parked in the wait after the 8th or the 9th clock, arbitration loss, and stop detection on the bus. The block drives two pull-low enables, `scl_drive_low` and `sda_drive_low`. These are ORed with the bit engine's own enables outside the block. While a stop is pending, the engine keeps SCL low, because the bus sits in a wait. When a stop is taken in the wait after the 8th clock, the release of SCL that the sequence performs is the high phase of the 9th clock. The stop therefore lands there, and no acknowledge slot completes. All ports are plain control and status signals, so no valid/ready handshake applies.

Top module: `i2c_stop_ctrl`

## Requirements
- R1: A control write with the stop bit set is taken only while `st_master` is 1. In slave mode, `stop_trig` stays 0.
- R2: A control write that sets both the stop bit and the start bit leaves `stop_trig` at 0. The start request in that write is still taken, and `start_go` is 1 for one cycle, one clock after the write.
- R3: A stop write is taken only at the selected wait point. When `wd_wait9` is 1, `st_wait9` must be 1. When `wd_wait9` is 0, `st_wait8` must be 1. A stop write made outside a wait, while a byte is moving, is ignored.
- R4: When the block is a receiver (`st_tx` = 0), a stop write is taken only if the same write carries `wd_ack_en` = 0, which marks the last received byte.
- R5: After a stop write is taken, the block holds SDA and SCL low for LOW_CYC clocks and then releases SCL. After SCL is sampled high, it waits SETUP_CYC clocks and then releases SDA. With the default values (4 and 4) and SCL rising at once, `sda_drive_low` is 1 for 9 cycles and `scl_drive_low` is 1 for 4 cycles.
- R6: While SCL is released but held low by another device, the block waits for `scl_in` to go high. Each stretched cycle adds exactly one cycle to the SDA-low time.
- R7: A second stop write while `stop_trig` is 1 has no effect. The running sequence keeps its timing and does not restart.
- R8: `st_arb_lost` clears `stop_trig` and releases both lines on the next clock.
- R9: A control write with the release bit set, a control write with the enable bit at 0, or a stored enable of 0 clears `stop_trig` and releases both lines. While the stored enable is 0, stop writes are not taken.
- R10: `st_bus_stop` while `stop_trig` is 1 clears `stop_trig` and produces a `stop_done` pulse exactly one cycle long.
- R11: A start write made while `stop_trig` is 1 is ignored, and `start_go` stays 0.
- R12: After reset, `stop_trig`, `stop_done`, `start_go` and both drive enables are 0, and the stored enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control-word write strobe |
| wd_stop | input | 1 | Write data: stop request |
| wd_start | input | 1 | Write data: start request |
| wd_release | input | 1 | Write data: leave the transfer |
| wd_enable | input | 1 | Write data: controller enable, stored |
| wd_ack_en | input | 1 | Write data: acknowledge enable (0 marks the last received byte) |
| wd_wait9 | input | 1 | Write data: wait point, 1 = after 9th clock, 0 = after 8th |
| st_master | input | 1 | Engine status: master role |
| st_tx | input | 1 | Engine status: transmitter role |
| st_wait8 | input | 1 | Engine status: parked in the wait after the 8th clock |
| st_wait9 | input | 1 | Engine status: parked in the wait after the 9th clock |
| st_arb_lost | input | 1 | Engine status: arbitration lost |
| st_bus_stop | input | 1 | Engine status: stop condition seen on the bus |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| stop_trig | output | 1 | Stop request readback |
| stop_done | output | 1 | One-cycle strobe on stop detection |
| start_go | output | 1 | One-cycle strobe for a start request that was taken |

## Verification
The hardest state to reach is a taken stop that is still in flight. This state is needed when a second stop write, a start write, arbitration loss or an SCL stretch must arrive while the sequence is partway through. The bench first brings the engine status into a legal wait, then issues the stop write. It then injects the disturbing event at a counted cycle inside the SDA-low or SCL-release phase. The bench measures the time the line enables stay low, sample by sample, against the phase lengths that the requirements give.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_SDA_LOW = 3'd1,
    SQ_SCL_REL = 3'd2,
    SQ_SETUP   = 3'd3,
    SQ_SDA_REL = 3'd4
  } seq_state_t;

  function automatic logic drives_sda(input seq_state_t s);
    return (s == SQ_SDA_LOW) || (s == SQ_SCL_REL) || (s == SQ_SETUP);
  endfunction

  function automatic logic drives_scl(input seq_state_t s);
    return (s == SQ_SDA_LOW);
  endfunction

endpackage

// File: rtl/i2c_stop_gate.sv
module i2c_stop_gate (
  input  logic ctl_wr,
  input  logic wd_stop,
  input  logic wd_start,
  input  logic wd_release,
  input  logic wd_enable,
  input  logic wd_ack_en,
  input  logic wd_wait9,
  input  logic enable_q,
  input  logic trig_q,
  input  logic st_master,
  input  logic st_tx,
  input  logic st_wait8,
  input  logic st_wait9,
  input  logic st_arb_lost,
  input  logic st_bus_stop,
  output logic stop_accept,
  output logic start_accept,
  output logic clear_req
);
  logic wait_ok;
  logic rx_ok;
  logic wr_clear;

  always_comb begin
    wait_ok  = wd_wait9 ? st_wait9 : st_wait8;
    rx_ok    = st_tx | ~wd_ack_en;
    wr_clear = ctl_wr & (wd_release | ~wd_enable);
    clear_req = st_arb_lost | st_bus_stop | ~enable_q | wr_clear;
    stop_accept = ctl_wr & wd_stop & ~wd_start & wd_enable & enable_q &
                  st_master & ~trig_q & wait_ok & rx_ok & ~clear_req;
    start_accept = ctl_wr & wd_start & wd_enable & ~trig_q & ~clear_req;
  end
endmodule

// File: rtl/i2c_stop_delay.sv
module i2c_stop_delay #(
  parameter int unsigned CW    = 3,
  parameter int unsigned LOADV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(LOADV);
    end else if (step && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
  import i2c_stop_pkg::*;
#(
  parameter int unsigned LOW_CYC   = 4,
  parameter int unsigned SETUP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic abort,
  input  logic scl_in,
  output logic scl_drv,
  output logic sda_drv
);
  localparam int unsigned MAXC = (LOW_CYC > SETUP_CYC) ? LOW_CYC : SETUP_CYC;
  localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam int unsigned LOW_LD   = (LOW_CYC   == 0) ? 0 : LOW_CYC - 1;
  localparam int unsigned SETUP_LD = (SETUP_CYC == 0) ? 0 : SETUP_CYC - 1;

  seq_state_t st_q, st_d;
  logic low_zero, set_zero;
  logic low_load, set_load;

  assign low_load = (st_q == SQ_IDLE) && go;
  assign set_load = (st_q == SQ_SCL_REL) && scl_in;

  i2c_stop_delay #(.CW(CW), .LOADV(LOW_LD)) u_low_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .load (low_load),
    .step (st_q == SQ_SDA_LOW),
    .zero (low_zero)
  );

  i2c_stop_delay #(.CW(CW), .LOADV(SETUP_LD)) u_setup_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .load (set_load),
    .step (st_q == SQ_SETUP),
    .zero (set_zero)
  );

  always_comb begin
    st_d = st_q;
    if (abort) begin
      st_d = SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE:    if (go) st_d = SQ_SDA_LOW;
        SQ_SDA_LOW: if (low_zero) st_d = SQ_SCL_REL;
        SQ_SCL_REL: if (scl_in) st_d = SQ_SETUP;
        SQ_SETUP:   if (set_zero) st_d = SQ_SDA_REL;
        SQ_SDA_REL: st_d = SQ_SDA_REL;
        default:    st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign scl_drv = drives_scl(st_q);
  assign sda_drv = drives_sda(st_q);
endmodule

// File: rtl/i2c_stop_ctrl.sv
module i2c_stop_ctrl #(
  parameter int unsigned LOW_CYC   = 4,
  parameter int unsigned SETUP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic wd_stop,
  input  logic wd_start,
  input  logic wd_release,
  input  logic wd_enable,
  input  logic wd_ack_en,
  input  logic wd_wait9,
  input  logic st_master,
  input  logic st_tx,
  input  logic st_wait8,
  input  logic st_wait9,
  input  logic st_arb_lost,
  input  logic st_bus_stop,
  input  logic scl_in,
  output logic scl_drive_low,
  output logic sda_drive_low,
  output logic stop_trig,
  output logic stop_done,
  output logic start_go
);
  logic enable_q, trig_q, done_q, start_q;
  logic stop_accept, start_accept, clear_req;

  i2c_stop_gate u_gate (
    .ctl_wr      (ctl_wr),
    .wd_stop     (wd_stop),
    .wd_start    (wd_start),
    .wd_release  (wd_release),
    .wd_enable   (wd_enable),
    .wd_ack_en   (wd_ack_en),
    .wd_wait9    (wd_wait9),
    .enable_q    (enable_q),
    .trig_q      (trig_q),
    .st_master   (st_master),
    .st_tx       (st_tx),
    .st_wait8    (st_wait8),
    .st_wait9    (st_wait9),
    .st_arb_lost (st_arb_lost),
    .st_bus_stop (st_bus_stop),
    .stop_accept (stop_accept),
    .start_accept(start_accept),
    .clear_req   (clear_req)
  );

  i2c_stop_seq #(.LOW_CYC(LOW_CYC), .SETUP_CYC(SETUP_CYC)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (stop_accept),
    .abort  (clear_req),
    .scl_in (scl_in),
    .scl_drv(scl_drive_low),
    .sda_drv(sda_drive_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      trig_q   <= 1'b0;
      done_q   <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      if (ctl_wr) enable_q <= wd_enable;
      if (clear_req)        trig_q <= 1'b0;
      else if (stop_accept) trig_q <= 1'b1;
      done_q  <= trig_q & st_bus_stop;
      start_q <= start_accept;
    end
  end

  assign stop_trig = trig_q;
  assign stop_done = done_q;
  assign start_go  = start_q;
endmodule

// File: rtl/i2c_stop_ctrl_chk.sv
module i2c_stop_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_wr,
  input logic wd_stop,
  input logic wd_start,
  input logic wd_release,
  input logic st_master,
  input logic st_arb_lost,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic stop_trig,
  input logic stop_done,
  input logic start_go
);
  p_slave_no_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_trig && ctl_wr && wd_stop && !st_master) |=> !stop_trig);

  p_start_blocks_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_trig && ctl_wr && wd_start) |=> !stop_trig);

  p_scl_within_sda_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> sda_drive_low);

  p_sda_rises_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> !scl_drive_low);

  p_arb_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_arb_lost |=> (!stop_trig && !sda_drive_low));

  p_release_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wd_release) |=> !stop_trig);

  p_drive_needs_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> stop_trig);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !stop_done);

  p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> !stop_trig);

  p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |=> !start_go);
endmodule

bind i2c_stop_ctrl i2c_stop_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_wr       (ctl_wr),
  .wd_stop      (wd_stop),
  .wd_start     (wd_start),
  .wd_release   (wd_release),
  .st_master    (st_master),
  .st_arb_lost  (st_arb_lost),
  .scl_drive_low(scl_drive_low),
  .sda_drive_low(sda_drive_low),
  .stop_trig    (stop_trig),
  .stop_done    (stop_done),
  .start_go     (start_go)
);

// File: tb/i2c_stop_ctrl_tb_top.sv
module i2c_stop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // bits: [7]master [6]tx [5]wait8 [4]wait9 [3]cfg_wait9 [2]ack_en [1]start [0]expect_taken
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1110_0101, 8'b0110_0100, 8'b1110_0110, 8'b1100_0100,
    8'b1110_1100, 8'b1101_1101, 8'b1001_1100, 8'b1001_1001
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, wd_stop = 0, wd_start = 0, wd_release = 0;
  logic wd_enable = 0, wd_ack_en = 0, wd_wait9 = 0;
  logic st_master = 1, st_tx = 1, st_wait8 = 1, st_wait9 = 0;
  logic st_arb_lost = 0, st_bus_stop = 0, scl_hold = 0;
  logic scl_in, scl_drive_low, sda_drive_low, stop_trig, stop_done, start_go;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  assign scl_in = ~scl_drive_low & ~scl_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wd_stop(wd_stop),
    .wd_start(wd_start), .wd_release(wd_release), .wd_enable(wd_enable),
    .wd_ack_en(wd_ack_en), .wd_wait9(wd_wait9), .st_master(st_master),
    .st_tx(st_tx), .st_wait8(st_wait8), .st_wait9(st_wait9),
    .st_arb_lost(st_arb_lost), .st_bus_stop(st_bus_stop), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .stop_trig(stop_trig), .stop_done(stop_done), .start_go(start_go)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic stp, input logic sta, input logic rel,
                          input logic en, input logic ack, input logic w9);
    @(negedge clk);
    ctl_wr = 1; wd_stop = stp; wd_start = sta; wd_release = rel;
    wd_enable = en; wd_ack_en = ack; wd_wait9 = w9;
    @(negedge clk);
    ctl_wr = 0; wd_stop = 0; wd_start = 0; wd_release = 0;
  endtask

  task automatic set_status(input logic m, input logic tx, input logic w8, input logic w9);
    @(negedge clk);
    st_master = m; st_tx = tx; st_wait8 = w8; st_wait9 = w9;
  endtask

  task automatic measure(input int hold, output int n_scl, output int n_sda);
    int rel = 0;
    n_scl = 0; n_sda = 0;
    scl_hold = (hold > 0);
    for (int g = 0; g < 100 && sda_drive_low; g++) begin
      n_sda++;
      if (scl_drive_low) n_scl++;
      else begin
        rel++;
        if (rel >= hold) scl_hold = 0;
      end
      @(negedge clk);
    end
    scl_hold = 0;
  endtask

  function automatic string tag_of(input int i);
    case (i)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R3";
      5: return "R3";
      6: return "R4";
      7: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic take_stop();
    set_status(1, 1, 1, 0);
    do_write(1, 0, 0, 1, 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ns, nd;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 stop_trig", stop_trig, 0);
    check("R12 sda", sda_drive_low, 0);
    check("R12 scl", scl_drive_low, 0);
    check("R12 done", stop_done, 0);
    check("R12 start", start_go, 0);
    rst_n = 1;
    // R12/R9: stored enable is 0 after reset, so a stop write is refused
    do_write(1, 0, 0, 1, 1, 0);
    check("R12 enable cleared", stop_trig, 0);
    do_write(0, 0, 0, 1, 1, 0);

    for (int i = 0; i < NVEC; i++) begin
      set_status(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      do_write(1, VEC[i][1], 0, 1, VEC[i][2], VEC[i][3]);
      check(tag_of(i), stop_trig, VEC[i][0]);
      check("R2 start_go", start_go, VEC[i][1]);
      do_write(0, 0, 1, 1, 1, 0);
      check("R9 release", stop_trig, 0);
    end

    // R5 nominal sequence, then R10
    take_stop();
    measure(0, ns, nd);
    check("R5 scl low cycles", ns, 4);
    check("R5 sda low cycles", nd, 9);
    check("R5 trig held", stop_trig, 1);
    st_bus_stop = 1;
    @(negedge clk);
    st_bus_stop = 0;
    check("R10 done", stop_done, 1);
    check("R10 trig cleared", stop_trig, 0);
    @(negedge clk);
    check("R10 done single", stop_done, 0);

    // R6 stretch
    take_stop();
    measure(3, ns, nd);
    check("R6 sda low stretched", nd, 11);
    do_write(0, 0, 1, 1, 1, 0);

    // R7 second write ignored
    take_stop();
    do_write(1, 0, 0, 1, 1, 0);
    measure(0, ns, nd);
    check("R7 scl remaining", ns, 2);
    check("R7 sda remaining", nd, 7);
    do_write(0, 0, 1, 1, 1, 0);

    // R11 start ignored during stop
    take_stop();
    do_write(0, 1, 0, 1, 1, 0);
    check("R11 start_go", start_go, 0);
    check("R11 trig kept", stop_trig, 1);
    do_write(0, 0, 1, 1, 1, 0);

    // R8 arbitration loss
    take_stop();
    @(negedge clk);
    st_arb_lost = 1;
    @(negedge clk);
    st_arb_lost = 0;
    check("R8 trig", stop_trig, 0);
    check("R8 sda", sda_drive_low, 0);

    // R9 disable
    take_stop();
    do_write(0, 0, 0, 0, 1, 0);
    check("R9 disable clears", stop_trig, 0);
    check("R9 disable sda", sda_drive_low, 0);
    do_write(1, 0, 0, 1, 1, 0);
    check("R9 refused while disabled", stop_trig, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule